// File: doc/BRIEF.md
# Configuration Manager Register Block

This block is the register front end that software uses to load a configuration image into a programmable-logic region. A plain 32-bit register bus (address, write strobe, write data, combinational read data) reaches a small set of registers. The block samples the mode-select strap pins and reports whether their encoding is usable, along with the clock ratio and bus width that the encoding implies. It drives a control vector onto the configuration pins. It tracks the configuration phase of the target in a mode state machine. On request it emits a counted burst of data-clock pulses. It also watches twelve configuration status pins and latches a pending interrupt bit on each falling edge.

The mode state machine has six states, and their codes are visible in the status register: `MD_OFF` (0), `MD_RESET` (1), `MD_CONFIG` (2), `MD_INIT` (3), `MD_USER` (4) and `MD_UNDEF` (5, the state after reset). Its transitions are:
- `PWR_LOSS`: from any state to `MD_OFF` when the sampled power pin is low.
- `PWR_UP`: from `MD_OFF` to `MD_RESET` once power returns.
- `HOLD`: from `MD_CONFIG`, `MD_INIT`, `MD_USER` or `MD_UNDEF` to `MD_RESET` while control enable and the reset-pull bit are both set.
- `RELEASE`: from `MD_RESET` to `MD_CONFIG` when that pair is no longer both set.
- `CFG_DONE`: from `MD_CONFIG` to `MD_INIT` when the sampled conf-done pin is high.
- `INIT_DONE`: from `MD_INIT` to `MD_USER` when the sampled init-done pin is high.

The data-clock generator has three states:
- `DK_IDLE`: no pulses are pending.
- `DK_LOW`: the clock is low and the remaining count is checked. The generator goes to `DK_HIGH` if the count is nonzero. If the count is zero it returns to `DK_IDLE` and sets the done flag.
- `DK_HIGH`: the clock is high for one cycle. The generator decrements the count and returns to `DK_LOW`.

Top module: `cfgmgr_regs`

## Requirements
- R1: While reset is held, the registers read as follows: status (0x000) 0x45, control (0x004) 0x200, pulse count (0x008) 0, pulse status (0x00C) 0 and interrupt enable (0x830) 0. `ctrl_o` is 0x200 and both `dclk_o` and `irq_o` are low.
- R2: Status at 0x000 has the mode code in bits 2:0 and the mode-select pins in bits 7:3, sampled one cycle earlier; bits 31:8 read zero. Writes to the status register have no effect.
- R3: The mode state machine follows the transitions listed above, using control bit 0 (enable) and bit 2 (reset pull), status pin 1 (conf-done) and pin 2 (init-done).
- R4: A low on status pin 11 (power), once it has been sampled, forces mode 0. When power returns, the mode passes through 1 to 2 if the reset pull is clear.
- R5: Control at 0x004 stores bits 9:0 and drives them on `ctrl_o`; bits 31:10 read zero. Addresses not listed in these requirements read zero, and writes to them have no effect.
- R6: `msel_bad_o` is high when the sampled mode-select value has bit 4 set or has both low bits set. `hint_width_o` equals mode-select bit 3. `hint_ratio_o` equals the low two bits, plus one when the width bit is set and those bits are nonzero.
- R7: Writing N>0 to 0x008 produces exactly N one-cycle high pulses on `dclk_o`, with each pulse followed by at least one low cycle. Bit 0 of 0x00C then reads 1, and 0x008 reads back the pulses still to send (0 at the end).
- R8: Writing 0 to 0x008 sets the done flag at the next edge without any pulse. Writing a nonzero count clears the done flag.
- R9: A count written while pulses are still in progress abandons the rest of the old burst and sends the new count.
- R10: The done flag holds until bit 0 is written as 1 at 0x00C. Writing 0 there leaves it unchanged.
- R11: Reading 0x850 returns the twelve status pins in bits 11:0, sampled one cycle earlier, with the upper bits zero; writes to it are ignored.
- R12: A falling edge on any status pin latches that pin's pending bit. `irq_o` is the OR of the pending bits masked by the interrupt enable register at 0x830 (bits 11:0). A rising edge latches nothing.
- R13: Writing to 0x84C clears the pending bits whose write-data bit is 1 and leaves the others pending. The address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Register byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| msel_pins | input | 5 | Mode-select strap pins |
| pin_stat | input | 12 | Configuration status pins |
| ctrl_o | output | 10 | Control field outputs |
| dclk_o | output | 1 | Data-clock pulse output |
| irq_o | output | 1 | Masked interrupt request |
| msel_bad_o | output | 1 | Mode-select encoding unusable |
| hint_ratio_o | output | 2 | Clock-to-data ratio implied by mode-select |
| hint_width_o | output | 1 | Bus width implied by mode-select |

## Verification
On every cycle, the in-line properties check the following: mode persistence in user mode and the forced power-off, that a control value holds while it is not being written, that data-clock pulses never run back to back, that the done flag is sticky and that a zero count sets it, that falling edges latch, and that end-of-interrupt writes clear. Only the bench's scenarios can show the following: that exactly N pulses come out, that a count written part-way through a burst restarts it, the full walk through the configuration phases, the decode of several mode-select encodings, and the masking of pending bits by the enable register.

// File: rtl/cfgmgr_pkg.sv
`timescale 1ns/1ps
package cfgmgr_pkg;
    localparam int unsigned REG_AW  = 12;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned NPIN    = 12;
    localparam int unsigned MSEL_W  = 5;
    localparam int unsigned CTRL_W  = 10;

    localparam logic [REG_AW-1:0] A_STAT  = 12'h000;
    localparam logic [REG_AW-1:0] A_CTRL  = 12'h004;
    localparam logic [REG_AW-1:0] A_DCNT  = 12'h008;
    localparam logic [REG_AW-1:0] A_DSTAT = 12'h00C;
    localparam logic [REG_AW-1:0] A_IEN   = 12'h830;
    localparam logic [REG_AW-1:0] A_EOI   = 12'h84C;
    localparam logic [REG_AW-1:0] A_PINS  = 12'h850;

    localparam logic [CTRL_W-1:0] CTRL_RST = 10'h200;
    localparam logic [MSEL_W-1:0] MSEL_RST = 5'h08;

    localparam int unsigned CB_EN   = 0;
    localparam int unsigned CB_PULL = 2;
    localparam int unsigned PB_CDONE = 1;
    localparam int unsigned PB_IDONE = 2;
    localparam int unsigned PB_PWR   = 11;

    typedef enum logic [2:0] {
        MD_OFF    = 3'd0,
        MD_RESET  = 3'd1,
        MD_CONFIG = 3'd2,
        MD_INIT   = 3'd3,
        MD_USER   = 3'd4,
        MD_UNDEF  = 3'd5
    } cfg_mode_e;

    typedef enum logic [1:0] {
        DK_IDLE = 2'd0,
        DK_LOW  = 2'd1,
        DK_HIGH = 2'd2
    } dclk_st_e;
endpackage

// File: rtl/cfgmgr_mode_fsm.sv
`timescale 1ns/1ps
module cfgmgr_mode_fsm
    import cfgmgr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      smp_vld,
    input  logic      pwr_on,
    input  logic      conf_done,
    input  logic      init_done,
    input  logic      hold_rst,
    output cfg_mode_e mode_o
);
    cfg_mode_e st_q;
    cfg_mode_e st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= MD_UNDEF;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (smp_vld && !pwr_on) begin
            st_d = MD_OFF;                              // PWR_LOSS
        end else begin
            unique case (st_q)
                MD_OFF:    st_d = MD_RESET;             // PWR_UP
                MD_RESET:  if (!hold_rst) st_d = MD_CONFIG;   // RELEASE
                MD_CONFIG: begin
                    if (hold_rst)       st_d = MD_RESET;      // HOLD
                    else if (conf_done) st_d = MD_INIT;       // CFG_DONE
                end
                MD_INIT: begin
                    if (hold_rst)       st_d = MD_RESET;
                    else if (init_done) st_d = MD_USER;       // INIT_DONE
                end
                MD_USER:   if (hold_rst) st_d = MD_RESET;
                MD_UNDEF:  if (hold_rst) st_d = MD_RESET;
                default:   st_d = MD_UNDEF;
            endcase
        end
    end

    always_comb begin
        mode_o = st_q;
    end

    // R3
    user_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == MD_USER && !hold_rst && pwr_on) |=> (st_q == MD_USER));

    // R4
    pwr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && !pwr_on) |=> (mode_o == MD_OFF));
endmodule

// File: rtl/cfgmgr_dclk.sv
`timescale 1ns/1ps
module cfgmgr_dclk
    import cfgmgr_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             clr,
    output logic             dclk_o,
    output logic             done_o,
    output logic [CNT_W-1:0] rem_o
);
    dclk_st_e         st_q, st_d;
    logic [CNT_W-1:0] rem_q, rem_d;
    logic             done_q, done_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= DK_IDLE;
            rem_q  <= '0;
            done_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            rem_q  <= rem_d;
            done_q <= done_d;
        end
    end

    always_comb begin
        st_d   = st_q;
        rem_d  = rem_q;
        done_d = done_q;
        if (clr) done_d = 1'b0;
        if (ld) begin
            if (ld_val == '0) begin
                st_d   = DK_IDLE;
                rem_d  = '0;
                done_d = 1'b1;
            end else begin
                st_d   = DK_LOW;
                rem_d  = ld_val;
                done_d = 1'b0;
            end
        end else begin
            unique case (st_q)
                DK_IDLE: st_d = DK_IDLE;
                DK_LOW: begin
                    if (rem_q == '0) begin
                        st_d   = DK_IDLE;
                        done_d = 1'b1;
                    end else begin
                        st_d = DK_HIGH;
                    end
                end
                DK_HIGH: begin
                    rem_d = rem_q - 1'b1;
                    st_d  = DK_LOW;
                end
                default: st_d = DK_IDLE;
            endcase
        end
    end

    always_comb begin
        dclk_o = (st_q == DK_HIGH);
        done_o = done_q;
        rem_o  = rem_q;
    end

    // R7
    dclk_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dclk_o |=> !dclk_o);

    // R8
    zero_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && ld_val == '0) |=> (done_o && !dclk_o));

    // R10
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !clr && !ld) |=> done_o);
endmodule

// File: rtl/cfgmgr_pinmon.sv
`timescale 1ns/1ps
module cfgmgr_pinmon
    import cfgmgr_pkg::*;
#(
    parameter int unsigned NP = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NP-1:0] pins,
    input  logic          ien_we,
    input  logic [NP-1:0] ien_wdata,
    input  logic          eoi_we,
    input  logic [NP-1:0] eoi_mask,
    output logic [NP-1:0] pin_o,
    output logic [NP-1:0] ien_o,
    output logic          vld_o,
    output logic          irq_o
);
    logic [NP-1:0] pin_q, pin_qq, ien_q, pend_q, fall, clr_mask;
    logic          vld_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q  <= '0;
            pin_qq <= '0;
            ien_q  <= '0;
            vld_q  <= 1'b0;
        end else begin
            pin_q  <= pins;
            pin_qq <= pin_q;
            vld_q  <= 1'b1;
            if (ien_we) ien_q <= ien_wdata;
        end
    end

    always_comb begin
        fall     = pin_qq & ~pin_q;
        clr_mask = eoi_we ? eoi_mask : '0;
    end

    for (genvar i = 0; i < NP; i++) begin : g_latch
        always_ff @(posedge clk) begin
            if (!rst_n)          pend_q[i] <= 1'b0;
            else if (fall[i])    pend_q[i] <= 1'b1;
            else if (clr_mask[i]) pend_q[i] <= 1'b0;
        end
    end

    always_comb begin
        pin_o = pin_q;
        ien_o = ien_q;
        vld_o = vld_q;
        irq_o = |(pend_q & ien_q);
    end

    // R12
    fall_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|fall) |=> ((pend_q & $past(fall)) == $past(fall)));

    // R13
    eoi_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_we && fall == '0) |=> ((pend_q & $past(eoi_mask)) == '0));
endmodule

// File: rtl/cfgmgr_regs.sv
`timescale 1ns/1ps
module cfgmgr_regs
    import cfgmgr_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [REG_AW-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [MSEL_W-1:0]  msel_pins,
    input  logic [NPIN-1:0]    pin_stat,
    output logic [CTRL_W-1:0]  ctrl_o,
    output logic               dclk_o,
    output logic               irq_o,
    output logic               msel_bad_o,
    output logic [1:0]         hint_ratio_o,
    output logic               hint_width_o
);
    localparam int unsigned PAD_STAT = DATA_W - MSEL_W - 3;

    logic [CTRL_W-1:0] ctrl_q;
    logic [MSEL_W-1:0] msel_q;
    logic              wr_ctrl, wr_dcnt, wr_dstat, wr_ien, wr_eoi;
    logic              dk_done;
    logic [CNT_W-1:0]  dk_rem;
    logic [NPIN-1:0]   pin_smp, ien_v;
    logic              smp_vld;
    cfg_mode_e         mode;

    always_comb begin
        wr_ctrl  = bus_we && (bus_addr == A_CTRL);
        wr_dcnt  = bus_we && (bus_addr == A_DCNT);
        wr_dstat = bus_we && (bus_addr == A_DSTAT);
        wr_ien   = bus_we && (bus_addr == A_IEN);
        wr_eoi   = bus_we && (bus_addr == A_EOI);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
            msel_q <= MSEL_RST;
        end else begin
            msel_q <= msel_pins;
            if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
        end
    end

    always_comb begin
        msel_bad_o   = msel_q[4] | (&msel_q[1:0]);
        hint_width_o = msel_q[3];
        hint_ratio_o = msel_q[1:0] + {1'b0, (msel_q[3] && (|msel_q[1:0]))};
        ctrl_o       = ctrl_q;
    end

    cfgmgr_mode_fsm u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_vld   (smp_vld),
        .pwr_on    (pin_smp[PB_PWR]),
        .conf_done (pin_smp[PB_CDONE]),
        .init_done (pin_smp[PB_IDONE]),
        .hold_rst  (ctrl_q[CB_EN] & ctrl_q[CB_PULL]),
        .mode_o    (mode)
    );

    cfgmgr_dclk #(.CNT_W(CNT_W)) u_dclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (wr_dcnt),
        .ld_val (bus_wdata[CNT_W-1:0]),
        .clr    (wr_dstat & bus_wdata[0]),
        .dclk_o (dclk_o),
        .done_o (dk_done),
        .rem_o  (dk_rem)
    );

    cfgmgr_pinmon #(.NP(NPIN)) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .pins      (pin_stat),
        .ien_we    (wr_ien),
        .ien_wdata (bus_wdata[NPIN-1:0]),
        .eoi_we    (wr_eoi),
        .eoi_mask  (bus_wdata[NPIN-1:0]),
        .pin_o     (pin_smp),
        .ien_o     (ien_v),
        .vld_o     (smp_vld),
        .irq_o     (irq_o)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_STAT:  bus_rdata = {{PAD_STAT{1'b0}}, msel_q, mode};
            A_CTRL:  bus_rdata = DATA_W'(ctrl_q);
            A_DCNT:  bus_rdata = DATA_W'(dk_rem);
            A_DSTAT: bus_rdata = DATA_W'(dk_done);
            A_IEN:   bus_rdata = DATA_W'(ien_v);
            A_PINS:  bus_rdata = DATA_W'(pin_smp);
            default: bus_rdata = '0;
        endcase
    end

    // R5
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(ctrl_o));
endmodule

// File: tb/sim_cfgmgr_regs.sv
`timescale 1ns/1ps
module sim_cfgmgr_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [4:0]  msel = 5'h00;
    logic [11:0] pins = 12'h800;
    logic [9:0]  ctrl;
    logic        dclk, irq, mbad, hwid;
    logic [1:0]  hrat;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    cfgmgr_regs u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
        .bus_wdata(wdata), .bus_rdata(rdata), .msel_pins(msel),
        .pin_stat(pins), .ctrl_o(ctrl), .dclk_o(dclk), .irq_o(irq),
        .msel_bad_o(mbad), .hint_ratio_o(hrat), .hint_width_o(hwid)
    );

    // {address, write data, expected read-back}
    localparam logic [75:0] VEC [10] = '{
        {12'h004, 32'hFFFF_FFFF, 32'h0000_03FF},   // R5
        {12'h004, 32'h0000_0155, 32'h0000_0155},   // R5
        {12'h004, 32'h0000_0000, 32'h0000_0000},   // R5
        {12'h830, 32'hFFFF_FFFF, 32'h0000_0FFF},   // R12
        {12'h830, 32'h0000_0A5A, 32'h0000_0A5A},   // R12
        {12'h830, 32'h0000_0000, 32'h0000_0000},   // R12
        {12'h84C, 32'h0000_0FFF, 32'h0000_0000},   // R13
        {12'h850, 32'hFFFF_FFFF, 32'h0000_0800},   // R11
        {12'h010, 32'hFFFF_FFFF, 32'h0000_0000},   // R5
        {12'h840, 32'h1234_5678, 32'h0000_0000}    // R5
    };

    function automatic string tag_of(input logic [11:0] a);
        case (a)
            12'h830: return "R12";
            12'h84C: return "R13";
            12'h850: return "R11";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        int np;
        cyc(3);
        // R1 reset values while reset is held
        rd(12'h000, r); check("R1 status", r, 32'h45);
        rd(12'h004, r); check("R1 control", r, 32'h200);
        rd(12'h008, r); check("R1 count", r, 0);
        rd(12'h00C, r); check("R1 done", r, 0);
        rd(12'h830, r); check("R1 enable", r, 0);
        check("R1 ctrl_o", 32'(ctrl), 32'h200);
        check("R1 dclk/irq", {30'b0, dclk, irq}, 0);
        rst_n = 1'b1;
        cyc(2);

        for (int i = 0; i < 10; i++) begin
            wr(VEC[i][75:64], VEC[i][63:32]);
            rd(VEC[i][75:64], r);
            check(tag_of(VEC[i][75:64]), r, VEC[i][31:0]);
            if (VEC[i][75:64] == 12'h004)
                check("R5 ctrl_o", 32'(ctrl), VEC[i][31:0]);
        end

        // R6 mode-select decode
        msel = 5'h0A; cyc(2);
        rd(12'h000, r); check("R2 msel field", 32'(r[7:3]), 32'h0A);
        check("R6 0A", {28'b0, mbad, hwid, hrat}, {28'b0, 1'b0, 1'b1, 2'd3});
        msel = 5'h09; cyc(2);
        check("R6 09", {28'b0, mbad, hwid, hrat}, {28'b0, 1'b0, 1'b1, 2'd2});
        msel = 5'h08; cyc(2);
        check("R6 08", {28'b0, mbad, hwid, hrat}, {28'b0, 1'b0, 1'b1, 2'd0});
        msel = 5'h01; cyc(2);
        check("R6 01", {28'b0, mbad, hwid, hrat}, {28'b0, 1'b0, 1'b0, 2'd1});
        msel = 5'h13; cyc(2);
        check("R6 bit4 bad", 32'(mbad), 1);
        msel = 5'h03; cyc(2);
        check("R6 low bits bad", 32'(mbad), 1);
        msel = 5'h02; cyc(2);

        // R3 mode walk, currently CONFIG after the table
        rd(12'h000, r); check("R3 config", r, {24'b0, 5'h02, 3'd2});
        wr(12'h000, 32'hFFFF_FFFF);
        rd(12'h000, r); check("R2 write ignored", r, {24'b0, 5'h02, 3'd2});
        pins = 12'h802; cyc(3);
        rd(12'h000, r); check("R3 init", 32'(r[2:0]), 3);
        pins = 12'h806; cyc(3);
        rd(12'h000, r); check("R3 user", 32'(r[2:0]), 4);
        wr(12'h004, 32'h5); cyc(2);
        rd(12'h000, r); check("R3 hold reset", 32'(r[2:0]), 1);
        pins = 12'h800;
        wr(12'h004, 32'h1); cyc(2);
        rd(12'h000, r); check("R3 release", 32'(r[2:0]), 2);
        // R4 power loss and return
        pins = 12'h000; cyc(3);
        rd(12'h000, r); check("R4 off", 32'(r[2:0]), 0);
        pins = 12'h800; cyc(5);
        rd(12'h000, r); check("R4 repowered", 32'(r[2:0]), 2);

        // R12 / R13 interrupts
        wr(12'h84C, 32'hFFF);
        wr(12'h830, 32'h002); cyc(1);
        check("R12 idle irq", 32'(irq), 0);
        pins = 12'h802; cyc(3);
        check("R12 rising no irq", 32'(irq), 0);
        pins = 12'h800; cyc(3);
        check("R12 fall irq", 32'(irq), 1);
        wr(12'h84C, 32'h001); cyc(1);
        check("R13 other bit kept", 32'(irq), 1);
        wr(12'h84C, 32'h002); cyc(1);
        check("R13 cleared", 32'(irq), 0);
        pins = 12'h801; cyc(2); pins = 12'h800; cyc(3);
        check("R12 masked", 32'(irq), 0);
        wr(12'h830, 32'h001); cyc(1);
        check("R12 unmasked", 32'(irq), 1);
        wr(12'h84C, 32'h001); cyc(1);
        check("R13 clear bit0", 32'(irq), 0);

        // R7 five pulses
        wr(12'h008, 32'd5);
        np = 0;
        rd(12'h00C, r); check("R8 load clears done", r, 0);
        if (dclk) np++;
        for (int k = 0; k < 11; k++) begin
            @(negedge clk);
            if (dclk) np++;
        end
        check("R7 pulse count", 32'(np), 5);
        rd(12'h00C, r); check("R7 done", r, 1);
        rd(12'h008, r); check("R7 remaining", r, 0);
        // R10 done clearing
        wr(12'h00C, 32'h0);
        rd(12'h00C, r); check("R10 zero write keeps", r, 1);
        wr(12'h00C, 32'h1);
        rd(12'h00C, r); check("R10 w1c", r, 0);
        // R8 zero count
        wr(12'h008, 32'd0);
        rd(12'h00C, r); check("R8 zero count done", r, 1);
        check("R8 no pulse", 32'(dclk), 0);
        wr(12'h00C, 32'h1);
        // R9 restart
        wr(12'h008, 32'd6);
        np = 0;
        if (dclk) np++;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (dclk) np++;
        end
        wr(12'h008, 32'd3);
        if (dclk) np++;
        for (int k = 0; k < 15; k++) begin
            @(negedge clk);
            if (dclk) np++;
        end
        check("R9 restart pulses", 32'(np), 5);
        rd(12'h00C, r); check("R9 done", r, 1);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule